// File: doc/BRIEF.md
# I2C Line Monitor and Override

This block sits between the open-drain SCL and SDA pads and the I2C protocol engine. Each incoming line passes through a two-flop synchronizer and then a spike filter whose length, in system clock cycles, software can set. The filtered levels go to the protocol engine and are also shown in a small monitor word.

The same monitor word holds one control bit per line. Setting a control bit pulls that line low through the pad's output enable, and clearing it releases the line. Software uses this to bit-bang a recovery sequence, for example toggling SCL until a stuck target lets go of SDA. Each pad enable is the OR of the engine's pull-down request and the software bit, so neither source can release a line that the other holds low.

Configuration uses a single write port. A select bit chooses between the override bits and the filter length.

Top module: `i2c_line_guard`

## Requirements
- R1: After reset the filtered outputs are high, both pad enables are low and mon_rdata is 4'b0011.
- R2: Each raw pad level goes through two synchronizing flops. With a filter length of 0, a pad change held before clock edge k appears on the filtered output just after edge k+1, and not before.
- R3: With filter length L>0, a synchronized level change that lasts fewer than L consecutive cycles never reaches the filtered output.
- R4: With filter length L>0, a change that holds for L consecutive synchronized cycles reaches the filtered output on the edge that completes the L-th cycle, which is edge k+1+L for a pad change held before edge k.
- R5: A filter length of 0 bypasses the filter, so the filtered output equals the synchronizer output.
- R6: mon_rdata bit 0 shows the filtered SCL level and bit 1 shows the filtered SDA level. A rejected glitch leaves these bits unchanged.
- R7: A write with cfg_sel=0 loads the SCL control from cfg_wdata bit 2 and the SDA control from bit 3. A control bit of 1 drives that pad enable high (line pulled low), and 0 releases it.
- R8: mon_rdata bits 2 and 3 read back the last written SCL and SDA control values. A read-modify-write that changes only bit 2 leaves the SDA line unaffected.
- R9: Each pad enable is the OR of the engine's pull request and that line's control bit.
- R10: A write with cfg_sel=1 loads the filter length from cfg_wdata and leaves the control bits unchanged. A cfg_sel=0 write leaves the filter length unchanged.
- R11: The two lines are filtered independently: a change accepted on one line does not cause a glitch on the other to be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_pad_i | input | 1 | Raw SCL level from the pad |
| sda_pad_i | input | 1 | Raw SDA level from the pad |
| eng_scl_pull | input | 1 | Engine request to pull SCL low |
| eng_sda_pull | input | 1 | Engine request to pull SDA low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: override bits, 1: filter length |
| cfg_wdata | input | FLT_W | Configuration write data |
| scl_in_flt | output | 1 | Filtered SCL to the engine |
| sda_in_flt | output | 1 | Filtered SDA to the engine |
| scl_pad_oe | output | 1 | SCL open-drain enable (1 = drive low) |
| sda_pad_oe | output | 1 | SDA open-drain enable (1 = drive low) |
| mon_rdata | output | 4 | {SDA ctl, SCL ctl, SDA level, SCL level} |

## Verification
If a filter counter holds a wrong value, the filtered output moves one or more cycles early or late, or lets a glitch through. This shows on the filtered port and in the monitor level bits within L+2 cycles of a pad change. A wrong override register shows at once in the monitor control bits and on the pad enable one cycle after the write. A filter length loaded into the wrong register only becomes visible on the next pad change, so the bench follows each length write with pulses of length L-1 and L.

// File: rtl/i2c_guard_pkg.sv
package i2c_guard_pkg;
  localparam int NUM_LINES = 2;
  localparam int LN_SCL = 0;
  localparam int LN_SDA = 1;
  localparam int MON_W = 4;
  localparam int BIT_SCL_LVL = 0;
  localparam int BIT_SDA_LVL = 1;
  localparam int BIT_SCL_CTL = 2;
  localparam int BIT_SDA_CTL = 3;
  typedef enum logic {SEL_CTRL = 1'b0, SEL_FLEN = 1'b1} wsel_e;
endpackage

// File: rtl/lg_sync2.sv
module lg_sync2 #(
  parameter int W = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, stab_q;

  // R2: two flops per line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= {W{RST_VAL}};
      stab_q <= {W{RST_VAL}};
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;

  // R2
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(meta_q) != $past(stab_q) |-> stab_q == $past(meta_q));
endmodule

// File: rtl/lg_spike_filter.sv
module lg_spike_filter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic [CW-1:0] flen,
  output logic          dout
);
  logic [CW-1:0] cnt_q;
  logic          held_q;

  function automatic logic [CW:0] bump(input logic [CW-1:0] c);
    return {1'b0, c} + {{CW{1'b0}}, 1'b1};
  endfunction

  logic differs, bypass, expire;
  assign differs = (din != held_q);
  assign bypass  = (flen == '0);
  assign expire  = differs && !bypass && (bump(cnt_q) >= {1'b0, flen});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b1;
      cnt_q  <= '0;
    end else if (bypass) begin
      held_q <= din;
      cnt_q  <= '0;
    end else if (!differs) begin
      cnt_q  <= '0;
    end else if (expire) begin
      held_q <= din;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= bump(cnt_q)[CW-1:0];
    end
  end

  // R5: length 0 passes the synchronized level straight through
  assign dout = bypass ? din : held_q;

  // R4
  flt_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_q != $past(held_q) |-> held_q == $past(din));
  // R3
  flt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !differs |=> $stable(held_q));
endmodule

// File: rtl/i2c_line_guard.sv
module i2c_line_guard
  import i2c_guard_pkg::*;
#(
  parameter int FLT_W = 8,
  parameter int FLT_RST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_pad_i,
  input  logic             sda_pad_i,
  input  logic             eng_scl_pull,
  input  logic             eng_sda_pull,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [FLT_W-1:0] cfg_wdata,
  output logic             scl_in_flt,
  output logic             sda_in_flt,
  output logic             scl_pad_oe,
  output logic             sda_pad_oe,
  output logic [MON_W-1:0] mon_rdata
);
  localparam logic [FLT_W-1:0] FLEN_INIT = FLT_W'(FLT_RST);

  logic [NUM_LINES-1:0] raw_lv, sync_lv, flt_lv, ovr_q, eng_rq;
  logic [FLT_W-1:0]     flen_q;
  logic                 wr_ctrl, wr_flen;

  assign raw_lv = {sda_pad_i, scl_pad_i};
  assign eng_rq = {eng_sda_pull, eng_scl_pull};
  assign wr_ctrl = cfg_we && (wsel_e'(cfg_sel) == SEL_CTRL);
  assign wr_flen = cfg_we && (wsel_e'(cfg_sel) == SEL_FLEN);

  lg_sync2 #(.W(NUM_LINES), .RST_VAL(1'b1)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_lv), .q(sync_lv)
  );

  // R11: one filter per line
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    lg_spike_filter #(.CW(FLT_W)) i_flt (
      .clk(clk), .rst_n(rst_n), .din(sync_lv[g]), .flen(flen_q), .dout(flt_lv[g])
    );
  end

  // R7 R10
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q  <= '0;
      flen_q <= FLEN_INIT;
    end else begin
      if (wr_ctrl) ovr_q <= {cfg_wdata[BIT_SDA_CTL], cfg_wdata[BIT_SCL_CTL]};
      if (wr_flen) flen_q <= cfg_wdata;
    end
  end

  assign scl_in_flt = flt_lv[LN_SCL];
  assign sda_in_flt = flt_lv[LN_SDA];
  // R9
  assign scl_pad_oe = eng_rq[LN_SCL] | ovr_q[LN_SCL];
  assign sda_pad_oe = eng_rq[LN_SDA] | ovr_q[LN_SDA];
  // R6 R8
  assign mon_rdata = {ovr_q[LN_SDA], ovr_q[LN_SCL], flt_lv[LN_SDA], flt_lv[LN_SCL]};

  // R7
  ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> scl_pad_oe >= $past(cfg_wdata[BIT_SCL_CTL]) && sda_pad_oe >= $past(cfg_wdata[BIT_SDA_CTL]));
  // R8
  ctl_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> mon_rdata[BIT_SDA_CTL] == $past(cfg_wdata[BIT_SDA_CTL]));
  // R10
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ovr_q));
  // R10
  flen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flen |=> $stable(flen_q));
  // R9
  eng_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rq[LN_SCL] |-> scl_pad_oe);
endmodule

// File: tb/test_i2c_line_guard.sv
module test_i2c_line_guard;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_pad_i = 1'b1, sda_pad_i = 1'b1, eng_scl_pull = 1'b0, eng_sda_pull = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic scl_in_flt, sda_in_flt, scl_pad_oe, sda_pad_oe;
  logic [3:0] mon_rdata;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2c_line_guard i_i2c_line_guard (
    .clk(clk), .rst_n(rst_n), .scl_pad_i(scl_pad_i), .sda_pad_i(sda_pad_i),
    .eng_scl_pull(eng_scl_pull), .eng_sda_pull(eng_sda_pull), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .scl_in_flt(scl_in_flt),
    .sda_in_flt(sda_in_flt), .scl_pad_oe(scl_pad_oe), .sda_pad_oe(sda_pad_oe),
    .mon_rdata(mon_rdata)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 mon", {4'h0, mon_rdata}, 8'h03);
    chk("R1 oe", {6'h0, sda_pad_oe, scl_pad_oe}, 8'h00);
    chk("R1 flt", {6'h0, sda_in_flt, scl_in_flt}, 8'h03);
  endtask

  task automatic t_sync_bypass;
    wr(1'b1, 8'd0);
    @(negedge clk); scl_pad_i = 1'b0;
    @(posedge clk); #1 chk("R2 one edge", {7'h0, scl_in_flt}, 8'h01);
    @(posedge clk); #1 chk("R2 R5 two edges", {7'h0, scl_in_flt}, 8'h00);
    chk("R6 mon level", {4'h0, mon_rdata}, 8'h02);
    @(negedge clk); scl_pad_i = 1'b1;
    repeat (2) @(posedge clk); #1 chk("R5 back high", {7'h0, scl_in_flt}, 8'h01);
  endtask

  task automatic t_glitch(input int len);
    logic seen = 1'b1;
    wr(1'b1, 8'(len));
    @(negedge clk); scl_pad_i = 1'b0;
    repeat (len - 1) @(negedge clk);
    scl_pad_i = 1'b1;
    for (int i = 0; i < len + 4; i++) begin
      @(negedge clk); seen = seen & scl_in_flt & mon_rdata[0];
    end
    chk("R3 R6 glitch rejected", {7'h0, seen}, 8'h01);
  endtask

  task automatic t_hold(input int len);
    wr(1'b1, 8'(len));
    @(negedge clk); scl_pad_i = 1'b0;
    repeat (len + 1) @(posedge clk); #1 chk("R4 not yet", {7'h0, scl_in_flt}, 8'h01);
    @(posedge clk); #1 chk("R4 accepted", {7'h0, scl_in_flt}, 8'h00);
    @(negedge clk); scl_pad_i = 1'b1;
    repeat (2 * len + 4) @(negedge clk);
    chk("R4 recovered", {7'h0, scl_in_flt}, 8'h01);
  endtask

  task automatic t_independent;
    logic scl_seen = 1'b1;
    wr(1'b1, 8'd3);
    @(negedge clk); sda_pad_i = 1'b0; scl_pad_i = 1'b0;
    @(negedge clk);
    @(negedge clk); scl_pad_i = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); scl_seen = scl_seen & scl_in_flt;
    end
    chk("R11 sda accepted", {7'h0, sda_in_flt}, 8'h00);
    chk("R11 scl rejected", {7'h0, scl_seen}, 8'h01);
    sda_pad_i = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_override;
    wr(1'b0, 8'h04);
    chk("R7 scl pulled", {6'h0, sda_pad_oe, scl_pad_oe}, 8'h01);
    chk("R8 readback", {4'h0, mon_rdata}, 8'h07);
    wr(1'b0, {4'h0, mon_rdata} | 8'h08);
    chk("R7 both pulled", {6'h0, sda_pad_oe, scl_pad_oe}, 8'h03);
    wr(1'b0, {4'h0, mon_rdata} & 8'hFB);
    chk("R8 sda kept", {6'h0, sda_pad_oe, scl_pad_oe}, 8'h02);
    wr(1'b1, 8'd2);
    chk("R10 ctl unchanged", {4'h0, mon_rdata}, 8'h0B);
    wr(1'b0, 8'h00);
    chk("R7 released", {6'h0, sda_pad_oe, scl_pad_oe}, 8'h00);
    t_glitch(2);
  endtask

  task automatic t_engine;
    @(negedge clk); eng_sda_pull = 1'b1; #1;
    chk("R9 engine sda", {6'h0, sda_pad_oe, scl_pad_oe}, 8'h02);
    chk("R9 ctl not set", {6'h0, mon_rdata[3:2]}, 8'h00);
    wr(1'b0, 8'h08);
    @(negedge clk); eng_sda_pull = 1'b0; #1;
    chk("R9 override holds", {6'h0, sda_pad_oe, scl_pad_oe}, 8'h02);
    eng_scl_pull = 1'b1; #1;
    chk("R9 both sources", {6'h0, sda_pad_oe, scl_pad_oe}, 8'h03);
    eng_scl_pull = 1'b0;
    wr(1'b0, 8'h00);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_sync_bypass();
    t_glitch(5);
    t_hold(5);
    t_hold(1);
    t_independent();
    t_override();
    t_engine();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule